// File: doc/BRIEF.md
# Dual-Loop Constant-Voltage / Constant-Current Mode Arbiter

This block sits between two digital loop regulators and the frequency actuator of a resonant converter. Each cycle it takes two frequency requests, one from the voltage loop and one from the current loop. It forwards the tighter of the two as a single switching-frequency command. In this converter a higher frequency means lower gain, so the tighter request is the larger code. The command is then held inside a programmable frequency window. A protection input overrides all of this and forces the command to the top of the window.

Next to the command path, a mode tracker reports whether the current loop (CC) or the voltage loop (CV) is considered in control. It decides this by comparing the output-current measurement against two separate thresholds. A mode change is committed only after the crossing condition has held for a programmable number of consecutive cycles. After each change the new mode is held for a programmable minimum dwell before qualification starts again. Every mode change increments a diagnostic toggle counter, so boundary chatter can be measured.

Top module: `cvcc_arbiter`

## Requirements
- R1: With `prot_force` low and the window not inverted, the command equals the larger of `cv_req` and `cc_req`, clamped to the window.
- R2: The command is clamped so that it never falls below `f_min` and never rises above `f_max`. If `f_min` > `f_max`, `f_max` wins.
- R3: While `prot_force` is high, the command equals `f_max`, whatever the requests are.
- R4: `cmd_freq` is registered. It reflects the inputs sampled at the previous rising clock edge. During reset it reads all ones.
- R5: Reset (active-low `rst_n`, asynchronous) puts the block in CV mode (`mode_cc` = 0), with the toggle counter at zero and the dwell timer expired.
- R6: In CV mode the qualifying condition is `i_meas` >= `th_enter`. In CC mode it is `i_meas` < `th_exit`. A current between the two thresholds never changes the mode.
- R7: A mode change commits at the N-th consecutive clock edge at which the condition holds, with N = `persist_len`. A value of 0 acts as 1. Any edge without the condition restarts the count from zero.
- R8: After a mode change, `dwell_len` edges pass before qualification counting resumes. The earliest next change is therefore `dwell_len` + N edges later.
- R9: `toggle_cnt` increments by one at every mode change and saturates at all ones. It never changes without a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cv_req | input | FW | Voltage-loop frequency request |
| cc_req | input | FW | Current-loop frequency request |
| i_meas | input | IW | Output-current measurement |
| th_enter | input | IW | Current level that qualifies entry to CC |
| th_exit | input | IW | Current level below which CC qualifies exit |
| persist_len | input | PW | Consecutive cycles needed to commit a change |
| dwell_len | input | DW | Minimum hold cycles after a change |
| f_min | input | FW | Lower frequency clamp |
| f_max | input | FW | Upper frequency clamp and protection value |
| prot_force | input | 1 | Protection override |
| cmd_freq | output | FW | Registered switching-frequency command |
| mode_cc | output | 1 | 1 = CC mode, 0 = CV mode |
| toggle_cnt | output | TW | Saturating count of mode changes |

## Verification
The hardest situation to reach is the point where the dwell timer and the persistence counter follow each other. A second mode change must wait for both, and a short-cut in either one moves the change by only a cycle. The stimulus commits one change with a nonzero dwell and then applies the exit condition immediately. It checks the mode one edge before the predicted commit edge and again at that edge. Holds with the current exactly on each threshold, and with a current between the two thresholds, pin down the edges of the hysteresis band.

// File: rtl/cvcc_pkg.sv
package cvcc_pkg;
    typedef enum logic {
        MODE_CV = 1'b0,
        MODE_CC = 1'b1
    } mode_e;
endpackage

// File: rtl/cvcc_req_select.sv
module cvcc_req_select #(
    parameter int FW = 12
) (
    input  logic [FW-1:0] cv_req,
    input  logic [FW-1:0] cc_req,
    input  logic [FW-1:0] f_min,
    input  logic [FW-1:0] f_max,
    input  logic          prot_force,
    output logic [FW-1:0] sel_freq
);
    logic [FW-1:0] tight;
    logic [FW-1:0] lo_clamped;

    always_comb begin
        // higher frequency = lower gain, so the larger code is the tighter request
        tight      = (cv_req >= cc_req) ? cv_req : cc_req;
        lo_clamped = (tight < f_min) ? f_min : tight;
        if (prot_force)
            sel_freq = f_max;
        else if (lo_clamped > f_max)
            sel_freq = f_max;
        else
            sel_freq = lo_clamped;
    end
endmodule

// File: rtl/cvcc_mode_qual.sv
module cvcc_mode_qual
    import cvcc_pkg::*;
#(
    parameter int IW = 12,
    parameter int PW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] i_meas,
    input  logic [IW-1:0] th_enter,
    input  logic [IW-1:0] th_exit,
    input  logic [PW-1:0] persist_len,
    input  logic [DW-1:0] dwell_len,
    output mode_e         mode,
    output logic          flip
);
    typedef struct packed {
        mode_e         mode;
        logic [PW-1:0] qual;
        logic [DW-1:0] dwell;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic          cond;
    logic [PW-1:0] need;
    logic [PW:0]   qual_next;

    always_comb begin
        st_d      = st_q;
        flip      = 1'b0;
        cond      = (st_q.mode == MODE_CV) ? (i_meas >= th_enter) : (i_meas < th_exit);
        need      = (persist_len == '0) ? PW'(1) : persist_len;
        qual_next = {1'b0, st_q.qual} + 1'b1;
        if (st_q.dwell != '0) begin
            st_d.dwell = st_q.dwell - 1'b1;
            st_d.qual  = '0;
        end else if (!cond) begin
            st_d.qual = '0;
        end else if (qual_next >= {1'b0, need}) begin
            flip       = 1'b1;
            st_d.mode  = (st_q.mode == MODE_CV) ? MODE_CC : MODE_CV;
            st_d.qual  = '0;
            st_d.dwell = dwell_len;
        end else begin
            st_d.qual = qual_next[PW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= MODE_CV;
            st_q.qual  <= '0;
            st_q.dwell <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;
endmodule

// File: rtl/cvcc_toggle_cnt.sv
module cvcc_toggle_cnt #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [TW-1:0] cnt
);
    localparam logic [TW-1:0] CNT_TOP = '1;
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != CNT_TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/cvcc_arbiter.sv
module cvcc_arbiter
    import cvcc_pkg::*;
#(
    parameter int FW = 12,
    parameter int IW = 12,
    parameter int PW = 8,
    parameter int DW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] cv_req,
    input  logic [FW-1:0] cc_req,
    input  logic [IW-1:0] i_meas,
    input  logic [IW-1:0] th_enter,
    input  logic [IW-1:0] th_exit,
    input  logic [PW-1:0] persist_len,
    input  logic [DW-1:0] dwell_len,
    input  logic [FW-1:0] f_min,
    input  logic [FW-1:0] f_max,
    input  logic          prot_force,
    output logic [FW-1:0] cmd_freq,
    output logic          mode_cc,
    output logic [TW-1:0] toggle_cnt
);
    localparam logic [FW-1:0] CMD_RST = '1;

    logic [FW-1:0] sel_freq;
    logic [FW-1:0] cmd_d, cmd_q;
    mode_e         mode;
    logic          flip;

    cvcc_req_select #(.FW(FW)) u_sel (
        .cv_req     (cv_req),
        .cc_req     (cc_req),
        .f_min      (f_min),
        .f_max      (f_max),
        .prot_force (prot_force),
        .sel_freq   (sel_freq)
    );

    cvcc_mode_qual #(.IW(IW), .PW(PW), .DW(DW)) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .i_meas      (i_meas),
        .th_enter    (th_enter),
        .th_exit     (th_exit),
        .persist_len (persist_len),
        .dwell_len   (dwell_len),
        .mode        (mode),
        .flip        (flip)
    );

    cvcc_toggle_cnt #(.TW(TW)) u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (flip),
        .cnt   (toggle_cnt)
    );

    always_comb begin
        cmd_d = sel_freq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= CMD_RST;
        else        cmd_q <= cmd_d;
    end

    assign cmd_freq = cmd_q;
    assign mode_cc  = (mode == MODE_CC);
endmodule

// File: rtl/cvcc_arbiter_chk.sv
module cvcc_arbiter_chk #(
    parameter int FW = 12,
    parameter int IW = 12,
    parameter int PW = 8,
    parameter int DW = 8,
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [FW-1:0] cv_req,
    input logic [FW-1:0] cc_req,
    input logic [IW-1:0] i_meas,
    input logic [IW-1:0] th_enter,
    input logic [IW-1:0] th_exit,
    input logic [DW-1:0] dwell_len,
    input logic [FW-1:0] f_min,
    input logic [FW-1:0] f_max,
    input logic          prot_force,
    input logic [FW-1:0] cmd_freq,
    input logic          mode_cc,
    input logic [TW-1:0] toggle_cnt
);
    localparam logic [TW-1:0]   TOG_TOP = '1;
    localparam logic [DW+1:0]   GAP_TOP = '1;

    logic            prev_q, started_q;
    logic [DW-1:0]   dl_q, dcap_q;
    logic [DW+1:0]   gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= 1'b0;
            started_q <= 1'b0;
            dl_q      <= '0;
            dcap_q    <= '0;
            gap_q     <= '0;
        end else begin
            prev_q <= mode_cc;
            dl_q   <= dwell_len;
            if (mode_cc != prev_q) begin
                started_q <= 1'b1;
                dcap_q    <= dl_q;
                gap_q     <= (DW+2)'(1);
            end else if (gap_q != GAP_TOP) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_CMD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cmd_freq <= $past(f_max)); // R2
    AST_CMD_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_force && f_min <= f_max) |=> cmd_freq >= $past(f_min)); // R2
    AST_PROT_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        prot_force |=> cmd_freq == $past(f_max)); // R3
    AST_TIGHTER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_force && f_min <= f_max) |=>
        ((cmd_freq >= $past(cv_req) || cmd_freq == $past(f_max)) &&
         (cmd_freq >= $past(cc_req) || cmd_freq == $past(f_max)))); // R1
    AST_ENTER_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_cc) |-> $past(i_meas >= th_enter)); // R6
    AST_EXIT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_cc) |-> $past(i_meas < th_exit)); // R6
    AST_TOGGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cc != $past(mode_cc) && $past(toggle_cnt) != TOG_TOP) |->
        toggle_cnt == $past(toggle_cnt) + 1'b1); // R9
    AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_cc) |-> $stable(toggle_cnt)); // R9
    AST_DWELL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && mode_cc != prev_q) |-> gap_q >= {2'b00, dcap_q} + 1'b1); // R8
endmodule

bind cvcc_arbiter cvcc_arbiter_chk #(
    .FW(FW), .IW(IW), .PW(PW), .DW(DW), .TW(TW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cv_req     (cv_req),
    .cc_req     (cc_req),
    .i_meas     (i_meas),
    .th_enter   (th_enter),
    .th_exit    (th_exit),
    .dwell_len  (dwell_len),
    .f_min      (f_min),
    .f_max      (f_max),
    .prot_force (prot_force),
    .cmd_freq   (cmd_freq),
    .mode_cc    (mode_cc),
    .toggle_cnt (toggle_cnt)
);

// File: tb/cvcc_arbiter_bench.sv
module cvcc_arbiter_bench;
    localparam int FW = 12;
    localparam int IW = 12;
    localparam int PW = 8;
    localparam int DW = 8;
    localparam int TW = 16;
    localparam int NVEC = 8;

    // {cv_req, cc_req, f_min, f_max, prot, expected cmd}
    localparam logic [60:0] VEC [NVEC] = '{
        {12'd1000, 12'd800,  12'd500,  12'd3000, 1'b0, 12'd1000},
        {12'd700,  12'd1500, 12'd500,  12'd3000, 1'b0, 12'd1500},
        {12'd200,  12'd300,  12'd500,  12'd3000, 1'b0, 12'd500},
        {12'd3500, 12'd100,  12'd500,  12'd3000, 1'b0, 12'd3000},
        {12'd1200, 12'd1200, 12'd500,  12'd3000, 1'b0, 12'd1200},
        {12'd1000, 12'd900,  12'd500,  12'd3000, 1'b1, 12'd3000},
        {12'd100,  12'd100,  12'd2000, 12'd1000, 1'b0, 12'd1000},
        {12'd4095, 12'd0,    12'd0,    12'd4095, 1'b0, 12'd4095}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] cv_req = '0, cc_req = '0, f_min = '0, f_max = '0;
    logic [IW-1:0] i_meas = '0, th_enter = '0, th_exit = '0;
    logic [PW-1:0] persist_len = '0;
    logic [DW-1:0] dwell_len = '0;
    logic          prot_force = 1'b0;
    logic [FW-1:0] cmd_freq;
    logic          mode_cc;
    logic [TW-1:0] toggle_cnt;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    cvcc_arbiter #(.FW(FW), .IW(IW), .PW(PW), .DW(DW), .TW(TW)) u_cvcc_arbiter (
        .clk, .rst_n, .cv_req, .cc_req, .i_meas, .th_enter, .th_exit,
        .persist_len, .dwell_len, .f_min, .f_max, .prot_force,
        .cmd_freq, .mode_cc, .toggle_cnt
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #2000000;
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        ticks(3);
        // R4 R5: reset values
        check("R4 reset cmd", int'(cmd_freq), 4095);
        check("R5 reset mode", int'(mode_cc), 0);
        check("R5 reset toggles", int'(toggle_cnt), 0);
        th_enter = 12'd100; th_exit = 12'd60;
        persist_len = 8'd4; dwell_len = 8'd5;
        rst_n = 1'b1;
        ticks(1);

        // R1 R2 R3 R4: command path table, one edge per vector
        for (int v = 0; v < NVEC; v++) begin
            {cv_req, cc_req, f_min, f_max, prot_force} = VEC[v][60:12];
            ticks(1);
            check($sformatf("R1/R2/R3 vec%0d", v), int'(cmd_freq), int'(VEC[v][11:0]));
        end
        prot_force = 1'b0;

        // R7: interrupted persistence restarts
        i_meas = 12'd120; ticks(3);
        check("R7 three edges no switch", int'(mode_cc), 0);
        i_meas = 12'd50; ticks(1);
        i_meas = 12'd120; ticks(3);
        check("R7 count restarted", int'(mode_cc), 0);
        ticks(1);
        check("R7 commit on 4th edge", int'(mode_cc), 1);
        check("R9 first toggle", int'(toggle_cnt), 1);

        // R8: dwell then persistence before exit
        i_meas = 12'd30; ticks(8);
        check("R8 still CC inside dwell+persist", int'(mode_cc), 1);
        ticks(1);
        check("R8 exit at dwell+persist", int'(mode_cc), 0);
        check("R9 second toggle", int'(toggle_cnt), 2);

        // R6: between thresholds holds CV
        i_meas = 12'd80; ticks(20);
        check("R6 band holds CV", int'(mode_cc), 0);
        // R6: equal to enter threshold qualifies
        i_meas = 12'd100; ticks(3);
        check("R6 enter pending", int'(mode_cc), 0);
        ticks(1);
        check("R6 enter at threshold", int'(mode_cc), 1);
        // R6: equal to exit threshold does not qualify exit
        i_meas = 12'd60; ticks(20);
        check("R6 exit threshold holds CC", int'(mode_cc), 1);
        check("R9 no toggle while holding", int'(toggle_cnt), 3);

        // R7: persistence of zero acts as one
        persist_len = 8'd0; dwell_len = 8'd0;
        i_meas = 12'd30; ticks(1);
        check("R7 zero persistence", int'(mode_cc), 0);
        check("R9 fourth toggle", int'(toggle_cnt), 4);

        finish_run();
    end
endmodule